// File: doc/BRIEF.md
# Shared Timer Prescaler with Synchronized Start

This block turns the system clock into count-enable strobes for three timer/counters. Timers 0 and 1 take their prescaled strobes from one free-running divider, "divider A". Timer 2 takes them from a second divider, "divider B". Each timer also has its own external clock pin. The pin passes through a two-flop synchronizer and an edge detector, and the detected edge is used directly, without any division. A 3-bit clock-select code per timer chooses what drives that timer's enable: stopped, the undivided clock, one of four divider taps, or the falling or rising external edge.

A small control register lets software halt the timers and restart them together. It is built around a two-state machine:

- **FREE**: the divider reset bits clear themselves. A reset written in this state lasts one cycle.
- **HOLD**: the reset bits keep whatever value was last written, so the affected dividers stay cleared and their timers get no prescaled strobe.

There are two transitions:

- **ENTER** (FREE to HOLD): a write with bit 7 set.
- **RELEASE** (HOLD to FREE): a write with bit 7 clear.

A release write with both reset bits at 0 lets every held divider start from zero on the same clock edge.

Top module: `shared_prescaler_top`

## Requirements
- R1: After reset the register reads 0x00, and with clock-select code 0 no enable output is ever asserted.
- R2: Register layout: bit 7 is the hold-mode bit, bit 1 is the divider B reset, bit 0 is the divider A reset. Bits 6 to 2 read 0, so writing 0xFF reads back 0x83.
- R3: In HOLD, the written reset bits are kept. A timer whose divider is held in reset gives no enable for codes 1 to 5.
- R4: A write with bit 7 clear and bits 1:0 at 0 clears both reset bits at the write edge. Counting from that edge, every timer on code 1 is enabled in each following cycle, and every timer on a tap code is first enabled in the cycle after edge N-1, where N is the divide ratio.
- R5: In FREE, writing 1 to a reset bit holds that divider in reset for exactly one cycle. The bit reads 1 in that cycle and 0 afterwards, and the divider restarts from zero at the next edge.
- R6: Codes 1, 2, 3, 4 and 5 give enables every 1, 8, 64, 256 and 1024 cycles respectively. For a tap code, the enable is high when the divider count modulo N equals N-1.
- R7: Code 0 gives no enable, whatever the dividers and pins are doing.
- R8: Code 6 gives a one-cycle enable on a falling pin edge and code 7 on a rising pin edge. The enable appears in the cycle after the second clock edge that follows the pin change, and a held divider has no effect on it.
- R9: Timers 0 and 1 follow divider A, which is reset by bit 0. Timer 2 follows divider B, which is reset by bit 1. Resetting one divider does not shift the phase of the other.
- R10: A write takes effect at the next clock edge. A write that sets bit 7 together with a reset bit enters HOLD with that reset already asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control register write data |
| rd_data_o | output | 8 | Control register read value |
| cs_i | input | 9 | Clock-select code per timer, 3 bits each, timer 0 in bits 2:0 |
| ext_clk_i | input | 3 | External clock pin per timer |
| cnt_en_o | output | 3 | Count-enable strobe per timer |

## Verification
The bench builds the block with its default parameters: three timers, two of them sharing divider A, and 10-bit dividers. With these values one release from HOLD can be followed through the full 1024-cycle divider period for every tap code, so every enable in that period is compared against the arithmetic model `j mod N == N-1`. The two-divider split lets a single-cycle reset of divider A be checked against the undisturbed phase of divider B. Short per-timer pin sequences check the edge selection and the two-edge synchronizer latency while both dividers are held.

// File: rtl/psc_pkg.sv
package psc_pkg;

    localparam int REG_W      = 8;
    localparam int HOLD_BIT   = 7;
    localparam int RST_A_BIT  = 0;
    localparam int RST_B_BIT  = 1;
    localparam int NUM_DIV    = 2;
    localparam int CS_W       = 3;

    typedef enum logic {
        ST_FREE = 1'b0,
        ST_HOLD = 1'b1
    } ctrl_st_e;

    typedef enum logic [CS_W-1:0] {
        CS_STOP  = 3'd0,
        CS_UNDIV = 3'd1,
        CS_DIV1  = 3'd2,
        CS_DIV2  = 3'd3,
        CS_DIV3  = 3'd4,
        CS_DIV4  = 3'd5,
        CS_FALL  = 3'd6,
        CS_RISE  = 3'd7
    } cs_e;

    typedef struct packed {
        logic undiv;
        logic div1;
        logic div2;
        logic div3;
        logic div4;
    } tap_t;

endpackage

// File: rtl/psc_ctrl.sv
module psc_ctrl
    import psc_pkg::*;
(
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    wr_en_i,
    input  logic [REG_W-1:0]        wr_data_i,
    output logic [REG_W-1:0]        rd_data_o,
    output logic [NUM_DIV-1:0]      div_clr_o
);

    ctrl_st_e               state_q, state_d;
    logic [NUM_DIV-1:0]     clr_q, clr_d;
    logic [REG_W-1:0]       unused_wr_bits;

    assign unused_wr_bits = wr_data_i;

    // next state and next reset bits
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE: clr_d = '0;
            ST_HOLD: clr_d = clr_q;
            default: clr_d = '0;
        endcase
        if (wr_en_i) begin
            state_d = wr_data_i[HOLD_BIT] ? ST_HOLD : ST_FREE;
            clr_d   = {wr_data_i[RST_B_BIT], wr_data_i[RST_A_BIT]};
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_FREE;
            clr_q   <= '0;
        end else begin
            state_q <= state_d;
            clr_q   <= clr_d;
        end
    end

    // outputs
    always_comb begin
        rd_data_o            = '0;
        rd_data_o[HOLD_BIT]  = (state_q == ST_HOLD);
        rd_data_o[RST_A_BIT] = clr_q[0];
        rd_data_o[RST_B_BIT] = clr_q[1];
        div_clr_o            = clr_q;
    end

    a_r3_hold_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_HOLD && !wr_en_i) |=> $stable(clr_q));

    a_r5_free_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_FREE && !wr_en_i) |=> (clr_q == '0));

    a_r10_same_write_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_data_i[HOLD_BIT]) |=>
            (state_q == ST_HOLD && clr_q[0] == $past(wr_data_i[RST_A_BIT])));

    a_r4_release_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !wr_data_i[HOLD_BIT] && wr_data_i[RST_B_BIT:RST_A_BIT] == 2'b00)
            |=> (clr_q == '0 && state_q == ST_FREE));

endmodule

// File: rtl/psc_divider.sv
module psc_divider
    import psc_pkg::*;
#(
    parameter int CW = 10,
    parameter int S1 = 3,
    parameter int S2 = 6,
    parameter int S3 = 8
) (
    input  logic    clk_i,
    input  logic    rst_ni,
    input  logic    clr_i,
    output tap_t    taps_o
);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     count_q <= '0;
        else if (clr_i)  count_q <= '0;
        else             count_q <= count_q + 1'b1;
    end

    always_comb begin
        taps_o.undiv = !clr_i;
        taps_o.div1  = !clr_i && (&count_q[S1-1:0]);
        taps_o.div2  = !clr_i && (&count_q[S2-1:0]);
        taps_o.div3  = !clr_i && (&count_q[S3-1:0]);
        taps_o.div4  = !clr_i && (&count_q);
    end

    a_r4_no_instant_tap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(clr_i) |-> !taps_o.div1);

    a_r6_div1_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
        taps_o.div1 |=> !taps_o.div1);

    a_r6_taps_nested: assert property (@(posedge clk_i) disable iff (!rst_ni)
        taps_o.div4 |-> (taps_o.div3 && taps_o.div2 && taps_o.div1));

endmodule

// File: rtl/psc_edge_detect.sv
module psc_edge_detect (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);

    logic sync1_q, sync2_q, last_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            last_q  <= 1'b0;
        end else begin
            sync1_q <= pin_i;
            sync2_q <= sync1_q;
            last_q  <= sync2_q;
        end
    end

    assign rise_o = sync2_q && !last_q;
    assign fall_o = !sync2_q && last_q;

    a_r8_rise_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);

    a_r8_fall_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |=> !fall_o);

    a_r8_edges_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rise_o && fall_o));

endmodule

// File: rtl/psc_select.sv
module psc_select
    import psc_pkg::*;
(
    input  logic [CS_W-1:0] cs_i,
    input  tap_t            taps_i,
    input  logic            rise_i,
    input  logic            fall_i,
    output logic            en_o
);

    always_comb begin
        unique case (cs_e'(cs_i))
            CS_STOP:  en_o = 1'b0;
            CS_UNDIV: en_o = taps_i.undiv;
            CS_DIV1:  en_o = taps_i.div1;
            CS_DIV2:  en_o = taps_i.div2;
            CS_DIV3:  en_o = taps_i.div3;
            CS_DIV4:  en_o = taps_i.div4;
            CS_FALL:  en_o = fall_i;
            CS_RISE:  en_o = rise_i;
            default:  en_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/shared_prescaler_top.sv
module shared_prescaler_top
    import psc_pkg::*;
#(
    parameter int NUM_TMR    = 3,
    parameter int NUM_SHARED = 2,
    parameter int CW         = 10
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        wr_en_i,
    input  logic [7:0]                  wr_data_i,
    output logic [7:0]                  rd_data_o,
    input  logic [NUM_TMR*CS_W-1:0]     cs_i,
    input  logic [NUM_TMR-1:0]          ext_clk_i,
    output logic [NUM_TMR-1:0]          cnt_en_o
);

    localparam int S1 = 3;
    localparam int S2 = 6;
    localparam int S3 = 8;

    logic [NUM_DIV-1:0] div_clr;
    tap_t               div_taps [NUM_DIV];

    psc_ctrl u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o),
        .div_clr_o (div_clr)
    );

    for (genvar d = 0; d < NUM_DIV; d++) begin : g_div
        psc_divider #(.CW(CW), .S1(S1), .S2(S2), .S3(S3)) u_div (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .clr_i  (div_clr[d]),
            .taps_o (div_taps[d])
        );
    end

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        localparam int DIV_IDX = (t < NUM_SHARED) ? 0 : 1;
        logic rise, fall;

        psc_edge_detect u_edge (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .pin_i  (ext_clk_i[t]),
            .rise_o (rise),
            .fall_o (fall)
        );

        psc_select u_sel (
            .cs_i   (cs_i[t*CS_W +: CS_W]),
            .taps_i (div_taps[DIV_IDX]),
            .rise_i (rise),
            .fall_i (fall),
            .en_o   (cnt_en_o[t])
        );

        a_r7_stop_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cs_i[t*CS_W +: CS_W] == CS_STOP) |-> !cnt_en_o[t]);

        a_r3_held_no_prescaled: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (div_clr[DIV_IDX] && cs_i[t*CS_W +: CS_W] != CS_FALL
                && cs_i[t*CS_W +: CS_W] != CS_RISE) |-> !cnt_en_o[t]);
    end

    a_r4_shared_in_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_i[CS_W-1:0] == cs_i[2*CS_W-1:CS_W] && cs_i[CS_W-1:0] < 3'd6)
            |-> (cnt_en_o[0] == cnt_en_o[1]));

endmodule

// File: tb/tb_shared_prescaler_top.sv
module tb_shared_prescaler_top;

    localparam int CLK_PERIOD = 10;
    localparam int NT = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [7:0]     wr_data = '0;
    logic [7:0]     rd_data;
    logic [3*NT-1:0] cs = '0;
    logic [NT-1:0]  ext = '0;
    logic [NT-1:0]  en;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shared_prescaler_top dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_data_o (rd_data),
        .cs_i      (cs),
        .ext_clk_i (ext),
        .cnt_en_o  (en)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // drive at a falling edge, captured at the next rising edge, return at the falling edge after it
    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_all_cs(input logic [2:0] c);
        cs = {c, c, c};
    endtask

    function automatic int ratio(input logic [2:0] c);
        case (c)
            3'd2: return 8;
            3'd3: return 64;
            3'd4: return 256;
            default: return 1024;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(rd_data == 8'h00, "R1 reset register", rd_data, 0);
        chk(en == '0, "R1 reset enables", en, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: code 0 stays silent over a full divider period with pins toggling
        set_all_cs(3'd0);
        for (int j = 0; j < 1100; j++) begin
            ext = (j % 3 == 0) ? ~ext : ext;
            @(negedge clk);
            chk(en == '0, "R7 code 0 silent", en, 0);
        end
        ext = '0;
        repeat (4) @(negedge clk);

        // R2: layout and unused bits
        wr(8'hFF);
        chk(rd_data == 8'h83, "R2 write FF reads 83", rd_data, 8'h83);
        wr(8'h00);
        chk(rd_data == 8'h00, "R2 release reads 00", rd_data, 0);

        // R10: hold and reset in one write hold from that cycle
        set_all_cs(3'd1);
        wr(8'h81);
        chk(rd_data == 8'h81, "R10 same-write hold", rd_data, 8'h81);
        chk(en[1:0] == 2'b00, "R10 timers 0/1 halted at once", en, 0);
        chk(en[2] == 1'b1, "R9 timer 2 unaffected by bit 0", en[2], 1);
        for (int j = 0; j < 30; j++) begin
            @(negedge clk);
            chk(rd_data == 8'h81, "R3 bits kept in hold", rd_data, 8'h81);
            chk(en[1:0] == 2'b00, "R3 held timers silent", en, 0);
        end

        // R3/R4/R6: sweep every prescaled code over a full period after a joint release
        for (int c = 1; c <= 5; c++) begin
            set_all_cs(3'(c));
            wr(8'h83);
            for (int j = 0; j < 20; j++) begin
                @(negedge clk);
                chk(en == '0, "R3 held, no prescaled enable", en, 0);
            end
            wr(8'h00);
            for (int j = 0; j < 1024; j++) begin
                logic e;
                e = (c == 1) ? 1'b1 : ((j % ratio(3'(c))) == ratio(3'(c)) - 1);
                chk(en == {NT{e}}, (c == 1) ? "R4 undivided after release" : "R6 tap phase and period", en, {NT{e}});
                @(negedge clk);
            end
        end

        // R5/R9: single-cycle reset of divider A while divider B keeps its phase
        set_all_cs(3'd2);
        wr(8'h83);
        wr(8'h00);
        for (int j = 0; j < 60; j++) begin
            logic ea, eb;
            eb = (j % 8 == 7);
            if (j < 20)       ea = (j % 8 == 7);
            else if (j == 20) ea = 1'b0;
            else              ea = ((j - 21) % 8 == 7);
            chk(en[1:0] == {ea, ea}, "R5 divider A restarts after pulse", en[1:0], {ea, ea});
            chk(en[2] == eb, "R9 divider B phase kept", en[2], eb);
            if (j == 20) chk(rd_data == 8'h01, "R5 bit reads 1 for one cycle", rd_data, 1);
            if (j == 21) chk(rd_data == 8'h00, "R5 bit self-clears", rd_data, 0);
            if (j == 19) begin wr_en = 1'b1; wr_data = 8'h01; end
            if (j == 20) wr_en = 1'b0;
            @(negedge clk);
        end

        // R8: external edges with both dividers held
        cs = {3'd7, 3'd7, 3'd6};
        wr(8'h83);
        for (int h = 2; h <= 5; h++) begin
            for (int lvl = 1; lvl >= 0; lvl--) begin
                ext = {NT{1'(lvl)}};
                for (int i = 1; i <= h; i++) begin
                    logic [NT-1:0] e;
                    @(negedge clk);
                    e = '0;
                    if (i == 2) e = (lvl == 1) ? 3'b110 : 3'b001;
                    chk(en == e, "R8 edge enable timing", en, e);
                end
            end
        end
        wr(8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule